// File: doc/BRIEF.md
# Wire Memory Read Sequencer

This block runs one read of a current-driven wire memory. A requester presents an address and a read request while the block is ready. The block captures the address and holds it on the wire-select output for the whole cycle. It then steps through a fixed sequence of timed phases. First it clears the output latches. Next it turns on the wire drive, and keeps the clear asserted while the drive current ramps. A short guard gap follows. Then a strobe window opens on the current plateau, so that sense pulses can set latch bits. A tail of drive follows, and the drive switches off. Finally the captured word is presented with a one-cycle valid pulse.

The latches can only be set. Two gates protect them. The clear holds them at zero until the ramp has ended, and the strobe admits sense pulses only inside the plateau window. Crosstalk pulses during the ramp are therefore rejected, and so is noise at any other time. Every phase length is a parameter counted in clock cycles. The defaults, for a 100 MHz clock, are:

- pre-clear: 2 cycles
- ramp hold: 20 cycles
- gap: 2 cycles
- strobe: 8 cycles
- tail: 4 cycles

With these defaults the drive lasts 34 cycles.

The state machine has seven states:

- `S_IDLE` goes to `S_PRECLEAR` when a request is seen.
- `S_PRECLEAR` goes to `S_RISE` when its count expires.
- `S_RISE` goes to `S_GAP` when its count expires.
- `S_GAP` goes to `S_STROBE` when its count expires.
- `S_STROBE` goes to `S_TAIL` when its count expires.
- `S_TAIL` goes to `S_DONE` when its count expires.
- `S_DONE` always returns to `S_IDLE` after one cycle.

Top module: `wire_rom_reader`

## Requirements
- R1: After reset, rd_ready is 1, and drive_en, latch_clr, sense_strobe and rd_valid are 0. rd_data is all zeros.
- R2: A request is accepted only while rd_ready is 1. The accepted address appears on wire_addr and stays unchanged until the cycle returns to idle. Requests made while busy are ignored.
- R3: latch_clr rises PRE_CYC cycles before drive_en rises. It then stays high for the first RISE_CYC cycles of drive, so it is high for PRE_CYC+RISE_CYC consecutive cycles in total.
- R4: drive_en is high for exactly RISE_CYC+GAP_CYC+STRB_CYC+TAIL_CYC consecutive cycles per read.
- R5: sense_strobe is high for exactly STRB_CYC consecutive cycles. It starts GAP_CYC cycles after latch_clr falls, is never high together with latch_clr, and is high only while drive_en is high. Drive then continues for TAIL_CYC further cycles.
- R6: While latch_clr is high, all rd_data bits are forced to 0. A word left from the previous read does not carry over.
- R7: A sense_in bit has no effect unless sense_strobe is high. Sense pulses during the pre-clear, ramp, gap and tail leave rd_data unchanged.
- R8: rd_valid is high for exactly one cycle, in the cycle after drive_en falls, and rd_data then holds the captured word. The latency from the accepting clock edge to rd_valid is PRE_CYC+RISE_CYC+GAP_CYC+STRB_CYC+TAIL_CYC cycles. rd_ready is 1 again in the following cycle.
- R9: Latch bits are set-only. The word delivered is the bitwise OR of sense_in over all strobe cycles, even when a bit's pulse ends before the window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Address of the wire to read |
| rd_ready | output | 1 | High in idle, when a request can be accepted |
| wire_addr | output | ADDR_W | Registered wire select, held for the whole cycle |
| drive_en | output | 1 | Wire drive enable |
| latch_clr | output | 1 | Clear to the output latches |
| sense_strobe | output | 1 | Strobe window that lets sense pulses set latches |
| sense_in | input | DATA_W | Digital sense pulses, one per bit |
| rd_data | output | DATA_W | Latched word |
| rd_valid | output | 1 | One-cycle pulse marking rd_data as the result |

## Verification
The embedded assertions check several rules on every cycle:

- Strobe and clear never overlap, and strobe only occurs under drive.
- Clear is already high when drive starts.
- The latches change only while clear or strobe is active, and a strobe can only add one bits.
- The wire address is stable while busy.
- Valid never lasts two cycles.

Some behaviours need the bench's scenarios to show them:

- The exact length of each phase and the end-to-end latency.
- The rejection of sense patterns injected during the ramp, gap and tail.
- The delivered word equalling the OR of the strobe-time patterns.
- The clearing of a previous all-ones word.
- The ignoring of requests made while busy.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_PRECLEAR = 3'd1,
        S_RISE     = 3'd2,
        S_GAP      = 3'd3,
        S_STROBE   = 3'd4,
        S_TAIL     = 3'd5,
        S_DONE     = 3'd6
    } wrs_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wrs_phase_timer.sv
module wrs_phase_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));

endmodule

// File: rtl/wrs_seq_fsm.sv
module wrs_seq_fsm
    import wrs_pkg::*;
#(
    parameter int PRE_CYC  = 2,
    parameter int RISE_CYC = 20,
    parameter int GAP_CYC  = 2,
    parameter int STRB_CYC = 8,
    parameter int TAIL_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ready,
    output logic accept,
    output logic drive_en,
    output logic clr,
    output logic strobe,
    output logic done
);

    localparam int MAX_LEN = max_of(max_of(max_of(PRE_CYC, RISE_CYC),
                                           max_of(GAP_CYC, STRB_CYC)), TAIL_CYC);
    localparam int CW = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] PRE_LIM  = CW'(PRE_CYC - 1);
    localparam logic [CW-1:0] RISE_LIM = CW'(RISE_CYC - 1);
    localparam logic [CW-1:0] GAP_LIM  = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] STRB_LIM = CW'(STRB_CYC - 1);
    localparam logic [CW-1:0] TAIL_LIM = CW'(TAIL_CYC - 1);

    wrs_state_e    state_q, state_d;
    logic          run;
    logic [CW-1:0] limit;
    logic          expired;

    wrs_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .limit   (limit),
        .expired (expired)
    );

    always_comb begin
        run   = 1'b1;
        limit = '0;
        unique case (state_q)
            S_PRECLEAR: limit = PRE_LIM;
            S_RISE:     limit = RISE_LIM;
            S_GAP:      limit = GAP_LIM;
            S_STROBE:   limit = STRB_LIM;
            S_TAIL:     limit = TAIL_LIM;
            default:    run   = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req)     state_d = S_PRECLEAR;
            S_PRECLEAR: if (expired) state_d = S_RISE;
            S_RISE:     if (expired) state_d = S_GAP;
            S_GAP:      if (expired) state_d = S_STROBE;
            S_STROBE:   if (expired) state_d = S_TAIL;
            S_TAIL:     if (expired) state_d = S_DONE;
            S_DONE:                  state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        ready    = 1'b0;
        drive_en = 1'b0;
        clr      = 1'b0;
        strobe   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            S_IDLE:     ready = 1'b1;
            S_PRECLEAR: clr = 1'b1;
            S_RISE:     begin clr = 1'b1; drive_en = 1'b1; end
            S_GAP:      drive_en = 1'b1;
            S_STROBE:   begin strobe = 1'b1; drive_en = 1'b1; end
            S_TAIL:     drive_en = 1'b1;
            S_DONE:     done = 1'b1;
            default:    ready = 1'b0;
        endcase
    end

    assign accept = ready && req;

    // R5
    strb_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && clr));

    // R5
    strb_in_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> drive_en);

    // R3
    clr_at_drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && !$past(drive_en)) |-> clr);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(drive_en));

endmodule

// File: rtl/wrs_latch_bank.sv
module wrs_latch_bank #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              strobe,
    input  logic [DATA_W-1:0] sense,
    output logic [DATA_W-1:0] q
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                q[b] <= 1'b0;
            end else if (strobe && sense[b]) begin
                q[b] <= 1'b1;
            end
        end
    end

    // R7
    hold_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !clr) |=> (q == $past(q)));

    // R9
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clr) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/wire_rom_reader.sv
module wire_rom_reader #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 8,
    parameter int PRE_CYC  = 2,
    parameter int RISE_CYC = 20,
    parameter int GAP_CYC  = 2,
    parameter int STRB_CYC = 8,
    parameter int TAIL_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [ADDR_W-1:0] wire_addr,
    output logic              drive_en,
    output logic              latch_clr,
    output logic              sense_strobe,
    input  logic [DATA_W-1:0] sense_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic              accept;
    logic [ADDR_W-1:0] addr_q;

    wrs_seq_fsm #(
        .PRE_CYC  (PRE_CYC),
        .RISE_CYC (RISE_CYC),
        .GAP_CYC  (GAP_CYC),
        .STRB_CYC (STRB_CYC),
        .TAIL_CYC (TAIL_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .ready    (rd_ready),
        .accept   (accept),
        .drive_en (drive_en),
        .clr      (latch_clr),
        .strobe   (sense_strobe),
        .done     (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= rd_addr;
        end
    end

    assign wire_addr = addr_q;

    wrs_latch_bank #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (latch_clr),
        .strobe (sense_strobe),
        .sense  (sense_in),
        .q      (rd_data)
    );

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |=> (rd_ready || $stable(wire_addr)));

endmodule

// File: tb/wire_rom_reader_tb.sv
module wire_rom_reader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 8;
    localparam int PRE_CYC  = 2;
    localparam int RISE_CYC = 20;
    localparam int GAP_CYC  = 2;
    localparam int STRB_CYC = 8;
    localparam int TAIL_CYC = 4;
    localparam int DRIVE_CYC = RISE_CYC + GAP_CYC + STRB_CYC + TAIL_CYC;
    localparam int LATENCY = PRE_CYC + DRIVE_CYC + 1;
    localparam int NVEC = 6;

    localparam logic [ADDR_W-1:0] V_ADDR [NVEC] = '{6'h05, 6'h3A, 6'h11, 6'h2C, 6'h00, 6'h3F};
    localparam logic [DATA_W-1:0] V_RISE [NVEC] = '{8'hFF, 8'h00, 8'h0F, 8'hFF, 8'hAA, 8'h00};
    localparam logic [DATA_W-1:0] V_SA   [NVEC] = '{8'h00, 8'hA5, 8'h80, 8'hFF, 8'h00, 8'h3C};
    localparam logic [DATA_W-1:0] V_SB   [NVEC] = '{8'h00, 8'h00, 8'h01, 8'hFF, 8'h00, 8'hC3};
    localparam logic [DATA_W-1:0] V_TAIL [NVEC] = '{8'hFF, 8'h00, 8'hF0, 8'hFF, 8'h55, 8'h00};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_ready;
    logic [ADDR_W-1:0] wire_addr;
    logic              drive_en;
    logic              latch_clr;
    logic              sense_strobe;
    logic [DATA_W-1:0] sense_in = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wire_rom_reader #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_CYC(PRE_CYC), .RISE_CYC(RISE_CYC),
        .GAP_CYC(GAP_CYC), .STRB_CYC(STRB_CYC), .TAIL_CYC(TAIL_CYC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ready(rd_ready), .wire_addr(wire_addr), .drive_en(drive_en),
        .latch_clr(latch_clr), .sense_strobe(sense_strobe), .sense_in(sense_in),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] rp,
                           input logic [DATA_W-1:0] sa, input logic [DATA_W-1:0] sb,
                           input logic [DATA_W-1:0] tp);
        int n_pre = 0, n_rise = 0, n_gap = 0, n_strb = 0, n_tail = 0;
        int n_obs = 0, clr_run = 0, drv_run = 0;
        bit seen_strb = 0, got = 0, addr_ok = 1, ready_ok = 1, clr_zero_ok = 1, overlap_bad = 0;
        logic [DATA_W-1:0] word = '0;
        @(negedge clk);
        rd_addr = a;
        rd_req  = 1'b1;
        @(negedge clk);
        rd_addr = ~a;
        for (int i = 0; i < 200 && !got; i++) begin
            n_obs++;
            if (rd_valid) begin
                got = 1;
                word = rd_data;
                rd_req = 1'b0;
                sense_in = '0;
                // R8: valid after drive ends, exact latency
                check(n_obs == LATENCY, "R8 latency", n_obs, LATENCY);
            end else begin
                if (rd_ready) ready_ok = 0;
                if (wire_addr != a) addr_ok = 0;
                if (latch_clr && sense_strobe) overlap_bad = 1;
                if (latch_clr && clr_run > 0 && rd_data != '0) clr_zero_ok = 0;
                if (latch_clr) clr_run++;
                if (drive_en) drv_run++;
                if (latch_clr && !drive_en) begin n_pre++; sense_in = rp; end
                else if (latch_clr && drive_en) begin n_rise++; sense_in = rp; end
                else if (sense_strobe) begin
                    seen_strb = 1;
                    sense_in = (n_strb % 2 == 0) ? sa : sb;
                    n_strb++;
                end else if (drive_en && !seen_strb) begin n_gap++; sense_in = tp; end
                else if (drive_en) begin n_tail++; sense_in = tp; end
                else sense_in = '0;
            end
            @(negedge clk);
        end
        check(got, "R8 valid seen", int'(got), 1);
        check(rd_ready && !rd_valid, "R8 back to ready", int'(rd_ready), 1);
        check(addr_ok && ready_ok, "R2 addr held / busy request ignored", int'(addr_ok), 1);
        check(n_pre == PRE_CYC, "R3 preclear cycles", n_pre, PRE_CYC);
        check(n_rise == RISE_CYC && clr_run == PRE_CYC + RISE_CYC, "R3 clear hold", clr_run,
              PRE_CYC + RISE_CYC);
        check(drv_run == DRIVE_CYC, "R4 drive length", drv_run, DRIVE_CYC);
        check(n_strb == STRB_CYC && n_gap == GAP_CYC && n_tail == TAIL_CYC && !overlap_bad,
              "R5 strobe window", n_strb, STRB_CYC);
        check(clr_zero_ok, "R6 clear forces zero", int'(clr_zero_ok), 1);
        check(word == (sa | sb), "R7 R9 captured word", word, sa | sb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(rd_ready && !drive_en && !latch_clr && !sense_strobe && !rd_valid && rd_data == '0,
              "R1 reset outputs", {rd_ready, drive_en, latch_clr, sense_strobe, rd_valid}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_ready && !drive_en, "R1 idle after release", int'(rd_ready), 1);

        for (int v = 0; v < NVEC; v++) begin
            do_read(V_ADDR[v], V_RISE[v], V_SA[v], V_SB[v], V_TAIL[v]);
        end

        // R7: idle sense activity leaves data untouched
        sense_in = 8'hFF;
        repeat (3) @(negedge clk);
        check(rd_data == (V_SA[NVEC-1] | V_SB[NVEC-1]), "R7 idle sense ignored", rd_data,
              V_SA[NVEC-1] | V_SB[NVEC-1]);
        sense_in = '0;

        // R1: reset in mid-cycle returns to idle
        @(negedge clk);
        rd_addr = 6'h15;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        repeat (PRE_CYC + RISE_CYC + GAP_CYC + 2) @(negedge clk);
        check(sense_strobe, "R5 strobe open mid-read", int'(sense_strobe), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(rd_ready && !drive_en && !sense_strobe && rd_data == '0, "R1 reset mid-read",
              {rd_ready, drive_en, sense_strobe}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(6'h2A, 8'h00, 8'h5A, 8'h00, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule